// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words (1 sign bit, 8 exponent bits with bias 127, 23 fraction bits) and returns a 32-bit product word together with overflow, underflow and invalid flags. The sign, the exponent sum and the 24-by-24-bit significand product are formed side by side. A later stage normalizes the product, chops the low bits off the fraction and packs the word. Operands with a zero exponent field, which includes denormals, count as zero. An exponent field of all ones marks infinity or NaN, and each such case yields a fixed, flagged result.

The block has three register stages: operand capture, product and exponent sum, and normalize and pack. An input presented with `in_valid` high comes out three clock edges later with `out_valid` high. A new operand pair may enter on every cycle, and gaps in `in_valid` pass through the pipeline as gaps in `out_valid`. The result word and flags are meaningful only while `out_valid` is high.

Top module: `fpmul_pipe`

## Requirements
- R1: For every result that is not invalid, bit 31 of `out_res` is the XOR of bit 31 of the two operands. This applies to zero, infinity, underflow and overflow results too. For example, 0xC0000000 × 0x40400000 gives 0xC0C00000, and 0xBF800000 × 0xBF800000 gives 0x3F800000.
- R2: `out_valid` equals the `in_valid` that was captured three rising edges earlier. Results come out in the order the operands went in, with one result for each valid input, and idle cycles on the input appear as idle cycles on the output.
- R3: For two normal operands whose 48-bit significand product has bit 47 clear, the result exponent field is Ea + Eb − 127. The result fraction is product bits 45 down to 23. For example, 0x3F800000 × 0x3F800000 gives 0x3F800000.
- R4: When product bit 47 is set, the result exponent field is Ea + Eb − 126 and the fraction is product bits 46 down to 24. For example, 0x3FC00000 × 0x3FC00000 gives 0x40100000.
- R5: Fraction bits below the kept 23 are discarded with no rounding. For example, 0x4015EEAB × 0x8C150400 gives 0x8CAE8C82.
- R6: An operand whose exponent field is 0 counts as zero, whatever its fraction bits. If neither operand has an exponent field of 255, the result is a signed zero (exponent and fraction all 0) with all three flags clear.
- R7: For normal operands, if the exponent after normalization is 255 or more, `out_ovf` is 1 and the result is a signed infinity (exponent field 0xFF, fraction 0). An exponent of exactly 254 is still a normal result with the flag clear.
- R8: For normal operands, `out_udf` is 1 and the result is a signed zero in two cases. The first is Ea + Eb < 127; this holds even when product bit 47 is set. The second is Ea + Eb = 127 with product bit 47 clear. When Ea + Eb = 127 and bit 47 is set, the exponent field becomes 1 and the result is normal; for example, 0x00C00000 × 0x3F400000 gives 0x00900000.
- R9: An exponent field of 255 with a nonzero fraction is a NaN. If either operand is a NaN, or if an infinity meets a zero operand, the result is 0x7FC00000 with `out_inv` = 1. Otherwise an infinity operand gives a signed infinity with `out_ovf` = 1.
- R10: While `rst_n` is low, `out_valid`, `out_res` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| out_valid | output | 1 | `out_res` and the flags hold a result |
| out_res | output | 32 | Product word |
| out_ovf | output | 1 | Result saturated to infinity (exponent overflow or infinity operand) |
| out_udf | output | 1 | Result flushed to zero by exponent underflow |
| out_inv | output | 1 | NaN operand or infinity times zero; the result is the fixed NaN word |

## Verification
The assertions check several properties on every cycle. They check the three-cycle valid latency and the sign of each non-invalid result. They check that any flagged result carries the matching fixed pattern: infinity for overflow, signed zero for underflow, the fixed NaN word for invalid. They check that a zero operand gives a clean signed zero. They also check that a bias-subtraction borrow seen in the middle stage always produces an underflowed output one cycle later. Only the bench's scenarios show the exact exponent and fraction values. These cover the one-bit normalization shift, truncation on the given vector, and the exact 254/255 and 0/1 exponent boundaries. They also cover the recovery of an exponent of 0 by the normalization increment, and the ordering of results through a stream with gaps.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;
    logic              zero;
    logic              inf;
    logic              nan;
  } opnd_t;

  typedef struct packed {
    logic              sign;
    logic [EXP_W:0]    esum;
    logic [PROD_W-1:0] prod;
    logic              zero;
    logic              inf;
    logic              nan;
  } mid_t;

  // Split a word into fields and classify it; a zero exponent flushes to zero.
  function automatic opnd_t f_unpack(input logic [WORD_W-1:0] w);
    opnd_t o;
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    e = w[WORD_W-2 -: EXP_W];
    f = w[FRAC_W-1:0];
    o.sign = w[WORD_W-1];
    o.exp  = e;
    o.zero = (e == '0);
    o.inf  = (e == '1) && (f == '0);
    o.nan  = (e == '1) && (f != '0);
    o.sig  = {(e != '0) && (e != '1), f};
    return o;
  endfunction

  // Bit-serial ripple addition of two exponent fields into a sum one bit wider.
  function automatic logic [EXP_W:0] f_ripple_add(input logic [EXP_W-1:0] a,
                                                  input logic [EXP_W-1:0] b);
    logic [EXP_W:0] s;
    logic c;
    c = 1'b0;
    for (int i = 0; i < EXP_W; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    s[EXP_W] = c;
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] f_inf_word(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] f_zero_word(input logic s);
    return {s, {(WORD_W-1){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] f_nan_word();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fpmul_unpack.sv
module fpmul_unpack
  import fpmul_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output opnd_t             opnd
);
  assign opnd = f_unpack(word);
endmodule

// File: rtl/fpmul_expadd.sv
module fpmul_expadd
  import fpmul_pkg::*;
(
  input  logic [EXP_W-1:0] ea,
  input  logic [EXP_W-1:0] eb,
  output logic [EXP_W:0]   esum
);
  assign esum = f_ripple_add(ea, eb);
endmodule

// File: rtl/fpmul_sigmul.sv
module fpmul_sigmul #(
  parameter int A_W = 24
) (
  input  logic [A_W-1:0]   a,
  input  logic [A_W-1:0]   b,
  output logic [2*A_W-1:0] p
);
  localparam int P_W = 2 * A_W;

  logic [P_W-1:0] pp [A_W];

  for (genvar i = 0; i < A_W; i++) begin : g_row
    assign pp[i] = b[i] ? ({{A_W{1'b0}}, a} << i) : '0;
  end

  always_comb begin
    logic [P_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < A_W; i++) begin
      acc = acc + pp[i];
    end
    p = acc;
  end
endmodule

// File: rtl/fpmul_pack.sv
module fpmul_pack
  import fpmul_pkg::*;
(
  input  mid_t              mid,
  output logic [WORD_W-1:0] res,
  output logic              ovf,
  output logic              udf,
  output logic              inv,
  output logic              norm_shift,
  output logic              exp_borrow
);
  localparam int EW2 = EXP_W + 2;

  logic [EW2-1:0]    e_unb;
  logic [EW2-1:0]    e_fin;
  logic [FRAC_W-1:0] frac;

  assign norm_shift = mid.prod[PROD_W-1];
  assign exp_borrow = ({1'b0, mid.esum} < EW2'(BIAS));
  assign e_unb      = {1'b0, mid.esum} - EW2'(BIAS);
  assign e_fin      = e_unb + EW2'(norm_shift);
  assign frac       = norm_shift ? mid.prod[PROD_W-2 -: FRAC_W]
                                 : mid.prod[PROD_W-3 -: FRAC_W];

  always_comb begin
    res = f_zero_word(mid.sign);
    ovf = 1'b0;
    udf = 1'b0;
    inv = 1'b0;
    if (mid.nan || (mid.inf && mid.zero)) begin
      res = f_nan_word();
      inv = 1'b1;
    end else if (mid.inf) begin
      res = f_inf_word(mid.sign);
      ovf = 1'b1;
    end else if (mid.zero) begin
      res = f_zero_word(mid.sign);
    end else if (exp_borrow || (e_fin == '0)) begin
      res = f_zero_word(mid.sign);
      udf = 1'b1;
    end else if (e_fin >= EW2'(EXP_MAX)) begin
      res = f_inf_word(mid.sign);
      ovf = 1'b1;
    end else begin
      res = {mid.sign, e_fin[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fpmul_pipe.sv
module fpmul_pipe
  import fpmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_res,
  output logic              out_ovf,
  output logic              out_udf,
  output logic              out_inv
);
  // Stage 1: operand capture
  logic              v1;
  logic [WORD_W-1:0] a1, b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      a1 <= '0;
      b1 <= '0;
    end else begin
      v1 <= in_valid;
      a1 <= in_a;
      b1 <= in_b;
    end
  end

  opnd_t             ua, ub;
  logic [EXP_W:0]    esum_c;
  logic [PROD_W-1:0] prod_c;

  fpmul_unpack u_unp_a (.word(a1), .opnd(ua));
  fpmul_unpack u_unp_b (.word(b1), .opnd(ub));
  fpmul_expadd u_expadd (.ea(ua.exp), .eb(ub.exp), .esum(esum_c));
  fpmul_sigmul #(.A_W(SIG_W)) u_sigmul (.a(ua.sig), .b(ub.sig), .p(prod_c));

  // Stage 2: product, exponent sum, sign and class
  logic v2;
  mid_t m2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      m2 <= '0;
    end else begin
      v2      <= v1;
      m2.sign <= ua.sign ^ ub.sign;
      m2.esum <= esum_c;
      m2.prod <= prod_c;
      m2.zero <= ua.zero | ub.zero;
      m2.inf  <= ua.inf | ub.inf;
      m2.nan  <= ua.nan | ub.nan;
    end
  end

  logic              spec2;
  logic              norm_shift, exp_borrow;
  logic [WORD_W-1:0] res_c;
  logic              ovf_c, udf_c, inv_c;

  assign spec2 = m2.zero | m2.inf | m2.nan;

  fpmul_pack u_pack (
    .mid(m2), .res(res_c), .ovf(ovf_c), .udf(udf_c), .inv(inv_c),
    .norm_shift(norm_shift), .exp_borrow(exp_borrow)
  );

  // Stage 3: packed result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_ovf   <= 1'b0;
      out_udf   <= 1'b0;
      out_inv   <= 1'b0;
    end else begin
      out_valid <= v2;
      out_res   <= res_c;
      out_ovf   <= ovf_c;
      out_udf   <= udf_c;
      out_inv   <= inv_c;
    end
  end
endmodule

// File: rtl/fpmul_chk.sv
module fpmul_chk
  import fpmul_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_res,
  input logic              out_ovf,
  input logic              out_udf,
  input logic              out_inv,
  input logic              v2,
  input logic              spec2,
  input logic              norm_shift,
  input logic              exp_borrow
);
  logic [1:0] cnt;
  logic [2:0] vq, sq, zq;
  logic       zero_in;

  assign zero_in = ((in_a[WORD_W-2 -: EXP_W] == '0) || (in_b[WORD_W-2 -: EXP_W] == '0)) &&
                   (in_a[WORD_W-2 -: EXP_W] != '1) && (in_b[WORD_W-2 -: EXP_W] != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      vq  <= '0;
      sq  <= '0;
      zq  <= '0;
    end else begin
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
      vq <= {vq[1:0], in_valid};
      sq <= {sq[1:0], in_a[WORD_W-1] ^ in_b[WORD_W-1]};
      zq <= {zq[1:0], zero_in};
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3) |-> (out_valid == vq[2]));

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && out_valid && !out_inv) |-> (out_res[WORD_W-1] == sq[2]));

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && out_valid && zq[2]) |->
      (out_res[WORD_W-2:0] == '0 && !out_ovf && !out_udf && !out_inv));

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |->
      (out_res[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && !out_udf && !out_inv));

  p_udf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_udf) |-> (out_res[WORD_W-2:0] == '0 && !out_inv));

  p_borrow_udf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !spec2 && exp_borrow) |=> (out_valid && out_udf));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !spec2 && !exp_borrow && norm_shift) |=>
      (out_ovf || out_res[WORD_W-2 -: EXP_W] != '0));

  p_inv_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv) |->
      (out_res == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));
endmodule

bind fpmul_pipe fpmul_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_res(out_res), .out_ovf(out_ovf),
  .out_udf(out_udf), .out_inv(out_inv), .v2(v2), .spec2(spec2),
  .norm_shift(norm_shift), .exp_borrow(exp_borrow)
);

// File: tb/fpmul_pipe_bench.sv
`timescale 1ns/1ps
module fpmul_pipe_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_ovf, out_udf, out_inv;

  always #10 clk = ~clk;

  fpmul_pipe u_fpmul_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_res(out_res), .out_ovf(out_ovf),
    .out_udf(out_udf), .out_inv(out_inv)
  );

  typedef struct packed {
    logic [31:0] res;
    logic        ovf;
    logic        udf;
    logic        inv;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  logic [2:0] vpipe = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Behavioural reference written from the requirements.
  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b);
    exp_t r;
    int ea, eb, e;
    longint ma, mb, p;
    bit s, na, nb, ia, ib, za, zb;
    r = '0;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    na = (ea == 255) && (a[22:0] != 0);
    nb = (eb == 255) && (b[22:0] != 0);
    ia = (ea == 255) && (a[22:0] == 0);
    ib = (eb == 255) && (b[22:0] == 0);
    za = (ea == 0);
    zb = (eb == 0);
    if (na || nb || ((ia || ib) && (za || zb))) begin
      r.res = 32'h7FC00000; r.inv = 1'b1;
    end else if (ia || ib) begin
      r.res = {s, 8'hFF, 23'd0}; r.ovf = 1'b1;
    end else if (za || zb) begin
      r.res = {s, 31'd0};
    end else begin
      ma = longint'({1'b1, a[22:0]});
      mb = longint'({1'b1, b[22:0]});
      p  = ma * mb;
      e  = ea + eb - 127;
      if (ea + eb < 127) begin
        r.res = {s, 31'd0}; r.udf = 1'b1;
      end else begin
        if (((p >> 47) & 1) == 1) begin
          e = e + 1;
          r.res = {s, 8'd0, 23'(p >> 24)};
        end else begin
          r.res = {s, 8'd0, 23'(p >> 23)};
        end
        if (e >= 255) begin
          r.res = {s, 8'hFF, 23'd0}; r.ovf = 1'b1;
        end else if (e == 0) begin
          r.res = {s, 31'd0}; r.udf = 1'b1;
        end else begin
          r.res[30:23] = 8'(e);
        end
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    #2;
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
    drive(a, b);
    eq.push_back(model(a, b));
    tq.push_back(tag);
  endtask

  task automatic send_lit(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] res, input string tag);
    exp_t x;
    drive(a, b);
    x = '0;
    x.res = res;
    eq.push_back(x);
    tq.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      in_valid = 1'b0;
      in_a = 32'hDEADBEEF;
      in_b = 32'h12345678;
    end
  endtask

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      vpipe <= '0;
    end else if (!done) begin
      check(out_valid == vpipe[2], "R2 valid latency", 64'(out_valid), 64'(vpipe[2]));
      if (out_valid) begin
        if (eq.size() == 0) begin
          check(1'b0, "R2 unexpected result", 64'(out_res), 64'd0);
        end else begin
          exp_t x;
          string t;
          x = eq.pop_front();
          t = tq.pop_front();
          check({out_res, out_ovf, out_udf, out_inv} == x, t,
                64'({out_res, out_ovf, out_udf, out_inv}), 64'(x));
        end
      end
      vpipe <= {vpipe[1:0], in_valid};
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", 64'(out_valid), 64'd0);
    check({out_res, out_ovf, out_udf, out_inv} == '0, "R10 outputs in reset",
          64'({out_res, out_ovf, out_udf, out_inv}), 64'd0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;

    // R5: truncation on the known vector
    send_lit(32'h4015EEAB, 32'h8C150400, 32'h8CAE8C82, "R5 truncation vector");
    // R3 / R4: exponent and normalization
    send_lit(32'h3F800000, 32'h3F800000, 32'h3F800000, "R3 no shift");
    send_lit(32'h3FC00000, 32'h3FC00000, 32'h40100000, "R4 shift by one");
    // R1: sign
    send_lit(32'hC0000000, 32'h40400000, 32'hC0C00000, "R1 mixed sign");
    send_lit(32'hBF800000, 32'hBF800000, 32'h3F800000, "R1 both negative");
    idle(2);
    // R6: zero and denormal flush
    send(32'h00000000, 32'h40000000, "R6 zero operand");
    send(32'h80000000, 32'h3F800000, "R6 negative zero");
    send(32'h00000001, 32'h7F000000, "R6 denormal flush");
    send(32'h4049AAAA, 32'h807FFFFF, "R6 negative denormal");
    // R7: overflow and its boundary
    send(32'h7F000000, 32'h7F000000, "R7 large overflow");
    send(32'hFF000000, 32'h40000000, "R7 exponent exactly 255");
    send(32'h7F000000, 32'h3F800000, "R7 exponent 254 stays normal");
    send(32'h7F7FFFFF, 32'h3FFFFFFF, "R7 overflow by normalization");
    // R8: underflow and recovery
    send(32'h00800000, 32'h00800000, "R8 deep underflow");
    send(32'h00800000, 32'h3F000000, "R8 exponent 0 without shift");
    send_lit(32'h00C00000, 32'h3F400000, 32'h00900000, "R8 exponent 0 recovered");
    send(32'h80C00000, 32'h3EC00000, "R8 borrow not recovered");
    // R9: special operands
    send(32'h7FC00001, 32'h3F800000, "R9 NaN operand");
    send(32'h7F800000, 32'h00000000, "R9 infinity times zero");
    send(32'hFF800000, 32'h40000000, "R9 infinity times finite");
    send(32'h7F800000, 32'hFF800000, "R9 infinity times infinity");
    send(32'h00000000, 32'h7F800001, "R9 zero times NaN");
    idle(3);

    // R2: stream with gaps, pseudo-random operands
    r = 32'h1234ABCD;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] xa, xb;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      xa = r;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      xb = r;
      if (i % 2 == 0) begin
        xa[30:29] = 2'b01;
        xb[30:29] = 2'b10;
      end
      if (r[3:0] == 4'd0) idle(1 + int'(r[5:4]));
      send(xa, xb, "R2 stream");
    end
    idle(6);
    check(eq.size() == 0, "R2 all results delivered", 64'(eq.size()), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule